// File: doc/BRIEF.md
# Interleaved Multi-Bank Byte Memory

This block is a byte-addressable memory of 32K locations assembled from sixteen identical storage banks, each 2K deep and one byte wide. A 15-bit address is split into a 4-bit bank index and an 11-bit offset inside that bank. The split is fixed at build time by a parameter. In low-order interleaving the bank index comes from the bottom of the address, so neighbouring bytes fall in different banks. In high-order interleaving it comes from the top, so each bank holds one contiguous 2K region.

Access goes through a single synchronous port. Writes take effect on the rising clock edge. Reads are combinational from the bank and offset that the current address selects. A one-hot bank-activity vector shows which bank the current request touches. This lets the surrounding logic, or a bench, see the physical layout that the chosen mapping produces.

Top module: `interleaved_byte_mem`

## Requirements
- R1: The memory holds 32768 independent bytes (16 banks of 2048 x 8), and each 15-bit address names exactly one byte.
- R2: When `req` and `wr` are both high at a rising clock edge, the byte `wdata` is stored at `addr`, and no other address changes.
- R3: `rdata` shows the byte stored at the current `addr` combinationally, whatever the level of `req` and `wr`, and a byte written at one edge is visible in the following cycle.
- R4: With the low-order mapping (MODE = MAP_LOW), the bank index is `addr[3:0]` and the offset is `addr[14:4]`.
- R5: With the high-order mapping (MODE = MAP_HIGH), the bank index is `addr[14:11]` and the offset is `addr[10:0]`.
- R6: While `req` is high, `bank_act` has exactly one bit set, at the position of the bank index; while `req` is low, `bank_act` is all zero.
- R7: A clock edge with `req` low, or with `wr` low, leaves every stored byte unchanged.
- R8: Under the low-order mapping, any 16 consecutive addresses that start on a multiple of 16 touch 16 different banks. Under the high-order mapping, they all touch the same bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| req | input | 1 | Access request; qualifies writes and the activity output |
| wr | input | 1 | Write strobe; a write happens when both this and req are high |
| addr | input | 15 | Byte address |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte at the current address, combinational |
| bank_act | output | 16 | One-hot indication of the bank touched by the current request |

## Verification
The mapping itself is the hardest thing to observe. Any bijective mapping reads back the same data, so a swap of bank and offset bits is invisible to a plain write-then-read test. The bench therefore builds one instance with each mapping and drives both with the same exhaustive sweep of all 32768 addresses. It checks `bank_act` against the expected bank at every access, and it merges the activity vectors over each aligned group of 16 addresses to confirm that the group spreads across banks or stays in one. Every address is then read back, which exposes a wrong offset split, because two addresses that collide in one bank overwrite each other's data.

// File: rtl/ibm_pkg.sv
package ibm_pkg;
  typedef enum logic {
    MAP_LOW  = 1'b0,
    MAP_HIGH = 1'b1
  } map_mode_e;
endpackage

// File: rtl/ibm_addr_split.sv
// Splits a byte address into bank index and in-bank offset, and decodes
// the one-hot bank activity vector.
module ibm_addr_split
  import ibm_pkg::*;
#(
  parameter int        BANK_W   = 4,
  parameter int        OFFSET_W = 11,
  parameter map_mode_e MODE     = MAP_LOW,
  localparam int       ADDR_W   = BANK_W + OFFSET_W,
  localparam int       NBANKS   = 1 << BANK_W
) (
  input  logic                req,
  input  logic [ADDR_W-1:0]   addr,
  output logic [BANK_W-1:0]   bank_idx,
  output logic [OFFSET_W-1:0] offset,
  output logic [NBANKS-1:0]   bank_act
);

  generate
    if (MODE == MAP_LOW) begin : g_low
      assign bank_idx = addr[BANK_W-1:0];
      assign offset   = addr[ADDR_W-1:BANK_W];
    end else begin : g_high
      assign bank_idx = addr[ADDR_W-1:OFFSET_W];
      assign offset   = addr[OFFSET_W-1:0];
    end
  endgenerate

  always_comb begin
    bank_act = '0;
    if (req) begin
      bank_act[bank_idx] = 1'b1;
    end
  end

endmodule

// File: rtl/ibm_bank.sv
// One byte-wide storage bank with a synchronous write port and an
// asynchronous read port.
module ibm_bank #(
  parameter int  OFFSET_W = 11,
  parameter int  DATA_W   = 8,
  localparam int DEPTH    = 1 << OFFSET_W
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [OFFSET_W-1:0] offset,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[offset] <= wdata;
    end
  end

  assign rdata = store[offset];

endmodule

// File: rtl/ibm_read_mux.sv
// Selects the read byte of the addressed bank.
module ibm_read_mux #(
  parameter int  BANK_W = 4,
  parameter int  DATA_W = 8,
  localparam int NBANKS = 1 << BANK_W
) (
  input  logic [BANK_W-1:0]            bank_idx,
  input  logic [NBANKS-1:0][DATA_W-1:0] bank_rdata,
  output logic [DATA_W-1:0]            rdata
);

  assign rdata = bank_rdata[bank_idx];

endmodule

// File: rtl/interleaved_byte_mem.sv
// Byte memory built from NBANKS identical banks with a build-time choice
// of low-order or high-order address interleaving.
module interleaved_byte_mem
  import ibm_pkg::*;
#(
  parameter int        BANK_W   = 4,
  parameter int        OFFSET_W = 11,
  parameter int        DATA_W   = 8,
  parameter map_mode_e MODE     = MAP_LOW,
  localparam int       ADDR_W   = BANK_W + OFFSET_W,
  localparam int       NBANKS   = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NBANKS-1:0] bank_act
);

  logic [BANK_W-1:0]             bank_idx;
  logic [OFFSET_W-1:0]           offset;
  logic [NBANKS-1:0][DATA_W-1:0] bank_rdata;
  logic                          wr_req;

  assign wr_req = req & wr;

  ibm_addr_split #(
    .BANK_W  (BANK_W),
    .OFFSET_W(OFFSET_W),
    .MODE    (MODE)
  ) u_split (
    .req     (req),
    .addr    (addr),
    .bank_idx(bank_idx),
    .offset  (offset),
    .bank_act(bank_act)
  );

  generate
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic bank_wr_en;
      assign bank_wr_en = wr_req & bank_act[b];

      ibm_bank #(
        .OFFSET_W(OFFSET_W),
        .DATA_W  (DATA_W)
      ) u_bank (
        .clk   (clk),
        .wr_en (bank_wr_en),
        .offset(offset),
        .wdata (wdata),
        .rdata (bank_rdata[b])
      );
    end
  endgenerate

  ibm_read_mux #(
    .BANK_W(BANK_W),
    .DATA_W(DATA_W)
  ) u_rmux (
    .bank_idx  (bank_idx),
    .bank_rdata(bank_rdata),
    .rdata     (rdata)
  );

endmodule

// File: rtl/ibm_checker.sv
// Port-level checks, sampled on the falling edge away from the write edge.
module ibm_checker
  import ibm_pkg::*;
#(
  parameter int        BANK_W   = 4,
  parameter int        OFFSET_W = 11,
  parameter int        DATA_W   = 8,
  parameter map_mode_e MODE     = MAP_LOW,
  localparam int       ADDR_W   = BANK_W + OFFSET_W,
  localparam int       NBANKS   = 1 << BANK_W
) (
  input logic              clk,
  input logic              req,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [NBANKS-1:0] bank_act
);

  logic              last_wr_seen = 1'b0;
  logic [ADDR_W-1:0] last_wr_addr = '0;
  logic [DATA_W-1:0] last_wr_data = '0;

  always @(posedge clk) begin
    last_wr_seen <= (req === 1'b1) && (wr === 1'b1);
    last_wr_addr <= addr;
    last_wr_data <= wdata;
  end

  always @(negedge clk) begin
    if (req === 1'b1) begin
      AST_ACT_ONEHOT: assert ($onehot(bank_act)) else $error("bank_act not one-hot"); // R6
      if (MODE == MAP_LOW) begin
        AST_LOW_BANK: assert (bank_act[addr[BANK_W-1:0]]) else $error("low map bank"); // R4
      end else begin
        AST_HIGH_BANK: assert (bank_act[addr[ADDR_W-1:OFFSET_W]]) else $error("high map bank"); // R5
      end
    end else if (req === 1'b0) begin
      AST_ACT_IDLE: assert (bank_act == '0) else $error("bank_act while idle"); // R6
    end
    if (last_wr_seen && addr == last_wr_addr) begin
      AST_READ_AFTER_WRITE: assert (rdata == last_wr_data) else $error("write not visible"); // R3
    end
  end

endmodule

bind interleaved_byte_mem ibm_checker #(
  .BANK_W  (BANK_W),
  .OFFSET_W(OFFSET_W),
  .DATA_W  (DATA_W),
  .MODE    (MODE)
) u_ibm_checker (
  .clk     (clk),
  .req     (req),
  .wr      (wr),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .bank_act(bank_act)
);

// File: tb/test_interleaved_byte_mem.sv
`timescale 1ns/1ps
module test_interleaved_byte_mem;
  import ibm_pkg::*;

  localparam int BANK_W = 4;
  localparam int OFF_W  = 11;
  localparam int ADDR_W = 15;
  localparam int NB     = 16;
  localparam int NADDR  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              req = 1'b0;
  logic              wr  = 1'b0;
  logic [ADDR_W-1:0] addr  = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rd_lo, rd_hi;
  logic [NB-1:0]     act_lo, act_hi;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  interleaved_byte_mem #(.MODE(MAP_LOW)) i_interleaved_byte_mem (
    .clk(clk), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rd_lo), .bank_act(act_lo));

  interleaved_byte_mem #(.MODE(MAP_HIGH)) i_interleaved_byte_mem_hi (
    .clk(clk), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rd_hi), .bank_act(act_hi));

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'(a) ^ 8'(a >> 7) ^ 8'(seed);
  endfunction

  function automatic logic [NB-1:0] exp_act(input int a, input bit high, input bit rq);
    logic [NB-1:0] v;
    v = '0;
    if (rq) v[high ? ((a >> OFF_W) & 15) : (a & 15)] = 1'b1;
    return v;
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk16(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %04h expected %04h", tag, act, exp);
    end
  endtask

  // Drive after the rising edge; outputs are sampled at the next falling edge.
  task automatic drive(input bit rq, input bit w, input int a, input logic [7:0] d);
    @(posedge clk);
    #1;
    req = rq; wr = w; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
  endtask

  initial begin
    logic [NB-1:0] grp_lo, grp_hi;
    // Idle state: no request, no activity (R6)
    @(negedge clk);
    chk16("R6 idle low", act_lo, '0);
    chk16("R6 idle high", act_hi, '0);

    // Fill every address, checking activity per access (R2, R4, R5, R6, R8)
    grp_lo = '0; grp_hi = '0;
    for (int a = 0; a < NADDR; a++) begin
      drive(1'b1, 1'b1, a, pat(a, 8'h5a));
      chk16("R4 low bank", act_lo, exp_act(a, 1'b0, 1'b1));
      chk16("R5 high bank", act_hi, exp_act(a, 1'b1, 1'b1));
      grp_lo |= act_lo; grp_hi |= act_hi;
      if ((a & 15) == 15) begin
        chk16("R8 low group spread", grp_lo, '1);
        chk16("R8 high group single", grp_hi, exp_act(a, 1'b1, 1'b1));
        grp_lo = '0; grp_hi = '0;
      end
    end
    drive(1'b0, 1'b0, 0, 8'h00);
    chk16("R6 idle after fill low", act_lo, '0);
    chk16("R6 idle after fill high", act_hi, '0);

    // Blocked writes: req low or wr low must not change anything (R7)
    for (int i = 0; i < 256; i++) begin
      int a;
      a = (i * 131 + 7) % NADDR;
      drive(1'b0, 1'b1, a, ~pat(a, 8'h5a));
      chk16("R7 req low act", act_lo, '0);
      drive(1'b1, 1'b0, a, ~pat(a, 8'h5a));
      drive(1'b0, 1'b0, a, 8'h00);
      chk8("R7 blocked write low", rd_lo, pat(a, 8'h5a));
      chk8("R7 blocked write high", rd_hi, pat(a, 8'h5a));
    end

    // Full readback with req low: combinational read, all bytes distinct (R1, R3)
    for (int a = 0; a < NADDR; a++) begin
      drive(1'b0, 1'b0, a, 8'h00);
      chk8("R1 readback low", rd_lo, pat(a, 8'h5a));
      chk8("R1 readback high", rd_hi, pat(a, 8'h5a));
    end

    // Single-byte overwrite at bank edges, neighbours untouched (R2, R3)
    for (int k = 0; k < 8; k++) begin
      int a;
      a = (k * 4097 + 2047) % NADDR;
      drive(1'b1, 1'b1, a, 8'hc3 ^ 8'(k));
      drive(1'b0, 1'b0, a, 8'h00);
      chk8("R3 written byte low", rd_lo, 8'hc3 ^ 8'(k));
      chk8("R3 written byte high", rd_hi, 8'hc3 ^ 8'(k));
      drive(1'b0, 1'b0, (a + 1) % NADDR, 8'h00);
      chk8("R2 neighbour up low", rd_lo, pat((a + 1) % NADDR, 8'h5a));
      chk8("R2 neighbour up high", rd_hi, pat((a + 1) % NADDR, 8'h5a));
      drive(1'b0, 1'b0, a - 1, 8'h00);
      chk8("R2 neighbour down low", rd_lo, pat(a - 1, 8'h5a));
      chk8("R2 neighbour down high", rd_hi, pat(a - 1, 8'h5a));
    end

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule